// File: doc/BRIEF.md
# I2C Serial Clock Divider Generator

This block produces the serial clock of an I2C bus master from a faster system clock. The low and the high half of each SCL period are timed separately. Each half takes its length from its own 16-bit divisor field, and every unit of a field stands for a fixed prescale of eight system clocks. One SCL period therefore lasts 8×((low+1)+(high+1)) system clocks, and the duty cycle can be set to whatever the bus timing needs. A symmetric divide-by-N cannot do this. The software that fills the register usually puts the larger half of an odd total into the high field.

Besides the level outputs for SCL, the generator gives a transfer engine a set of single-cycle timing strobes:
- the falling and rising SCL edges;
- the middle of the high phase, where SDA is sampled;
- a START/STOP placement point, which a standard-mode configuration bit can move later in the high phase to give more setup time;
- a data-change point in the low phase, placed by a small SDA hold-delay field.

A new divisor word is staged when it is written. It is applied only when a new SCL period begins, so no phase is ever cut short or stretched part-way through. When the block is disabled, SCL is released high and all counters clear.

Top module: `i2c_scl_divgen`

## Requirements
- R1: After reset, and while `enable` is low, `scl_high` is 1, `scl_low` is 0 and no strobe output pulses.
- R2: The low phase (`scl_low`=1) lasts exactly (L+1)×8 clock cycles, where L is bits 15:0 of the active divisor word.
- R3: The high phase (`scl_high`=1 inside a running period) lasts exactly (H+1)×8 clock cycles, where H is bits 31:16 of the active divisor word.
- R4: The first phase after `enable` rises is a low phase: the cycle after the first clock edge that samples `enable`=1 shows `scl_low`=1 with `scl_fall`=1. `scl_fall` pulses only in the first cycle of each low phase, and `scl_rise` pulses only in the first cycle of each high phase.
- R5: A divisor write does not change the period already running. The written word governs the next period that begins, including the first period after enable when it is written while disabled.
- R6: `mid_high` pulses once per high phase, (H+1)×4 cycles after the `scl_rise` cycle (the rise cycle is offset 0).
- R7: `start_point` pulses once per high phase. It falls at offset (H+1)×4 when `start_ext`=0 and at offset (H+1)×6 when `start_ext`=1.
- R8: `data_point` pulses once per low phase at offset 8×min(`sda_cfg`, L) from the `scl_fall` cycle (offset 0).
- R9: When `enable` drops, the next cycle shows `scl_high`=1 and `scl_low`=0. A later re-enable starts with a full-length low phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Run the SCL generator; low releases SCL and clears counters |
| div_we | input | 1 | Write strobe for the divisor word |
| div_wdata | input | 32 | Divisor word: low-phase field 15:0, high-phase field 31:16 |
| start_ext | input | 1 | Standard-mode start setup extension |
| sda_cfg | input | 4 | SDA hold delay in prescale units after the falling edge |
| scl_low | output | 1 | SCL is in its low phase |
| scl_high | output | 1 | SCL is high (released) |
| scl_fall | output | 1 | First cycle of a low phase |
| scl_rise | output | 1 | First cycle of a high phase |
| mid_high | output | 1 | Middle of the high phase |
| start_point | output | 1 | Placement point for START/STOP during the high phase |
| data_point | output | 1 | Point in the low phase where SDA may change |

## Verification
Any error in the phase counter or the prescaler shows up within one SCL period as a low or high phase of the wrong length. If the counter never returns to zero, the edge strobes vanish altogether. Divisor staging that is wrong shows at the ports in the period during which the write lands: the phase lengths change one period early. Faults in the offset arithmetic move `mid_high`, `start_point` or `data_point` within the same phase they belong to. The bench therefore measures every phase length and every strobe offset against values worked out from the fields, around writes and around disable and re-enable.

// File: rtl/sclgen_pkg.sv
package sclgen_pkg;

   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_LOW  = 2'd1,
      PH_HIGH = 2'd2
   } phase_e;

endpackage

// File: rtl/sclgen_prescale.sv
module sclgen_prescale #(
   parameter int unsigned PRESCALE = 8,
   localparam int unsigned PRE_W   = $clog2(PRESCALE)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   output logic [PRE_W-1:0] pre,
   output logic             wrap
);

   localparam bit IS_POW2 = ((PRESCALE & (PRESCALE - 1)) == 0);

   assign wrap = (pre == PRE_W'(PRESCALE - 1));

   generate
      if (IS_POW2) begin : g_pow2
         // free-running binary counter wraps by itself
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)   pre <= '0;
            else if (clr) pre <= '0;
            else          pre <= pre + 1'b1;
         end
      end else begin : g_mod
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     pre <= '0;
            else if (clr)   pre <= '0;
            else if (wrap)  pre <= '0;
            else            pre <= pre + 1'b1;
         end
      end
   endgenerate

   // a wrap is always followed by a zero count
   p_wrap_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
      wrap |=> (pre == '0));

endmodule

// File: rtl/sclgen_phase.sv
module sclgen_phase
   import sclgen_pkg::*;
#(
   parameter int unsigned DIV_W    = 16,
   parameter int unsigned RESET_LO = 0,
   parameter int unsigned RESET_HI = 0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               enable,
   input  logic               wrap,
   input  logic               div_we,
   input  logic [2*DIV_W-1:0] div_wdata,
   output phase_e             phase,
   output logic [DIV_W-1:0]   cnt,
   output logic [DIV_W-1:0]   act_lo,
   output logic [DIV_W-1:0]   act_hi
);

   logic [DIV_W-1:0] stg_lo, stg_hi;

   // staging register: captures software writes at any time
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stg_lo <= DIV_W'(RESET_LO);
         stg_hi <= DIV_W'(RESET_HI);
      end else if (div_we) begin
         stg_lo <= div_wdata[DIV_W-1:0];
         stg_hi <= div_wdata[2*DIV_W-1:DIV_W];
      end
   end

   // phase sequencer; active divisors reload only at period start
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase  <= PH_IDLE;
         cnt    <= '0;
         act_lo <= DIV_W'(RESET_LO);
         act_hi <= DIV_W'(RESET_HI);
      end else if (!enable) begin
         phase <= PH_IDLE;
         cnt   <= '0;
      end else begin
         unique case (phase)
            PH_IDLE: begin
               phase  <= PH_LOW;
               cnt    <= '0;
               act_lo <= stg_lo;
               act_hi <= stg_hi;
            end
            PH_LOW: begin
               if (wrap) begin
                  if (cnt == act_lo) begin
                     phase <= PH_HIGH;
                     cnt   <= '0;
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
            end
            PH_HIGH: begin
               if (wrap) begin
                  if (cnt == act_hi) begin
                     phase  <= PH_LOW;
                     cnt    <= '0;
                     act_lo <= stg_lo;
                     act_hi <= stg_hi;
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
            end
            default: begin
               phase <= PH_IDLE;
               cnt   <= '0;
            end
         endcase
      end
   end

   p_off_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |=> (phase == PH_IDLE));

   p_first_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_IDLE && enable) |=> (phase == PH_LOW));

   p_act_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_LOW && enable) |=> ($stable(act_lo) && $stable(act_hi)));

   p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_LOW) |-> (cnt <= act_lo));

   p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_HIGH) |-> (cnt <= act_hi));

   p_low_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_LOW && enable && !wrap) |=> (phase == PH_LOW));

endmodule

// File: rtl/sclgen_strobe.sv
module sclgen_strobe
   import sclgen_pkg::*;
#(
   parameter int unsigned DIV_W    = 16,
   parameter int unsigned PRESCALE = 8,
   parameter int unsigned SDA_W    = 4,
   localparam int unsigned PRE_W   = $clog2(PRESCALE)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  phase_e           phase,
   input  logic [PRE_W-1:0] pre,
   input  logic [DIV_W-1:0] cnt,
   input  logic [DIV_W-1:0] act_lo,
   input  logic [DIV_W-1:0] act_hi,
   input  logic             start_ext,
   input  logic [SDA_W-1:0] sda_cfg,
   output logic             scl_low,
   output logic             scl_high,
   output logic             scl_fall,
   output logic             scl_rise,
   output logic             mid_high,
   output logic             start_point,
   output logic             data_point
);

   localparam int unsigned POS_W   = DIV_W + PRE_W + 2;
   localparam int unsigned HALF    = PRESCALE / 2;
   localparam int unsigned THREE_Q = (PRESCALE * 3) / 4;
   localparam bit          IS_POW2 = ((PRESCALE & (PRESCALE - 1)) == 0);

   logic [POS_W-1:0] pos;        // clocks elapsed in the current phase
   logic [POS_W-1:0] hi_units;
   logic [POS_W-1:0] mid_off;
   logic [POS_W-1:0] late_off;
   logic [DIV_W-1:0] cfg_w;
   logic [DIV_W-1:0] hold_units;
   logic             at_unit;

   generate
      if (IS_POW2) begin : g_pos_cat
         assign pos = POS_W'({cnt, pre});
      end else begin : g_pos_mul
         assign pos = POS_W'(cnt) * POS_W'(PRESCALE) + POS_W'(pre);
      end
   endgenerate

   assign hi_units = POS_W'(act_hi) + 1'b1;
   assign mid_off  = hi_units * POS_W'(HALF);
   assign late_off = hi_units * POS_W'(THREE_Q);

   // hold delay clamps to the last unit of the low phase
   assign cfg_w      = DIV_W'(sda_cfg);
   assign hold_units = (cfg_w < act_lo) ? cfg_w : act_lo;
   assign at_unit    = (pre == '0);

   assign scl_low     = (phase == PH_LOW);
   assign scl_high    = (phase != PH_LOW);
   assign scl_fall    = (phase == PH_LOW)  && at_unit && (cnt == '0);
   assign scl_rise    = (phase == PH_HIGH) && at_unit && (cnt == '0);
   assign mid_high    = (phase == PH_HIGH) && (pos == mid_off);
   assign start_point = (phase == PH_HIGH) &&
                        (pos == (start_ext ? late_off : mid_off));
   assign data_point  = (phase == PH_LOW) && at_unit && (cnt == hold_units);

   p_edges_apart_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !(scl_fall && scl_rise));

   p_mid_after_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
      scl_rise |=> !mid_high);

   p_data_in_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
      data_point |-> scl_low);

   p_start_mid_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (start_point && !start_ext) |-> mid_high);

endmodule

// File: rtl/i2c_scl_divgen.sv
module i2c_scl_divgen
   import sclgen_pkg::*;
#(
   parameter int unsigned DIV_W    = 16,
   parameter int unsigned PRESCALE = 8,
   parameter int unsigned SDA_W    = 4,
   parameter int unsigned RESET_LO = 0,
   parameter int unsigned RESET_HI = 0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               enable,
   input  logic               div_we,
   input  logic [2*DIV_W-1:0] div_wdata,
   input  logic               start_ext,
   input  logic [SDA_W-1:0]   sda_cfg,
   output logic               scl_low,
   output logic               scl_high,
   output logic               scl_fall,
   output logic               scl_rise,
   output logic               mid_high,
   output logic               start_point,
   output logic               data_point
);

   localparam int unsigned PRE_W = $clog2(PRESCALE);

   generate
      if (PRESCALE < 4 || (PRESCALE % 4) != 0) begin : g_bad_prescale
         $error("PRESCALE must be a multiple of four");
      end
      if (DIV_W < 2) begin : g_bad_div
         $error("DIV_W must be at least two");
      end
      if (SDA_W > DIV_W) begin : g_bad_sda
         $error("SDA_W may not exceed DIV_W");
      end
   endgenerate

   phase_e           phase;
   logic [PRE_W-1:0] pre;
   logic             wrap;
   logic [DIV_W-1:0] cnt, act_lo, act_hi;
   logic             pre_clr;

   assign pre_clr = !enable || (phase == PH_IDLE);

   sclgen_prescale #(.PRESCALE(PRESCALE)) u_pre (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (pre_clr),
      .pre   (pre),
      .wrap  (wrap)
   );

   sclgen_phase #(
      .DIV_W    (DIV_W),
      .RESET_LO (RESET_LO),
      .RESET_HI (RESET_HI)
   ) u_phase (
      .clk       (clk),
      .rst_n     (rst_n),
      .enable    (enable),
      .wrap      (wrap),
      .div_we    (div_we),
      .div_wdata (div_wdata),
      .phase     (phase),
      .cnt       (cnt),
      .act_lo    (act_lo),
      .act_hi    (act_hi)
   );

   sclgen_strobe #(
      .DIV_W    (DIV_W),
      .PRESCALE (PRESCALE),
      .SDA_W    (SDA_W)
   ) u_strobe (
      .clk         (clk),
      .rst_n       (rst_n),
      .phase       (phase),
      .pre         (pre),
      .cnt         (cnt),
      .act_lo      (act_lo),
      .act_hi      (act_hi),
      .start_ext   (start_ext),
      .sda_cfg     (sda_cfg),
      .scl_low     (scl_low),
      .scl_high    (scl_high),
      .scl_fall    (scl_fall),
      .scl_rise    (scl_rise),
      .mid_high    (mid_high),
      .start_point (start_point),
      .data_point  (data_point)
   );

   p_idle_high_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |=> (scl_high && !scl_low && !scl_fall && !data_point));

endmodule

// File: tb/i2c_scl_divgen_tb.sv
module i2c_scl_divgen_tb;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        enable;
   logic        div_we;
   logic [31:0] div_wdata;
   logic        start_ext;
   logic [3:0]  sda_cfg;
   logic        scl_low, scl_high, scl_fall, scl_rise;
   logic        mid_high, start_point, data_point;

   int n_vec = 0;
   int n_bad = 0;

   always #4 clk = ~clk;

   i2c_scl_divgen u_dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .enable      (enable),
      .div_we      (div_we),
      .div_wdata   (div_wdata),
      .start_ext   (start_ext),
      .sda_cfg     (sda_cfg),
      .scl_low     (scl_low),
      .scl_high    (scl_high),
      .scl_fall    (scl_fall),
      .scl_rise    (scl_rise),
      .mid_high    (mid_high),
      .start_point (start_point),
      .data_point  (data_point)
   );

   task automatic chk(input string req, input int act, input int exp);
      n_vec++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic write_div(input int lo, input int hi);
      @(negedge clk);
      div_we    = 1'b1;
      div_wdata = {hi[15:0], lo[15:0]};
      @(negedge clk);
      div_we    = 1'b0;
   endtask

   // measures one full period starting at a scl_fall cycle
   task automatic meas(output int lo, output int hi, output int dat,
                       output int mid, output int sta, output int rise0);
      dat = -1; mid = -1; sta = -1; rise0 = 0;
      while (!scl_fall) @(negedge clk);
      lo = 0;
      while (scl_low) begin
         if (data_point) dat = lo;
         lo++;
         @(negedge clk);
      end
      hi = 0;
      while (!scl_fall) begin
         if (scl_rise) rise0 = rise0 + ((hi == 0) ? 1 : 100);
         if (mid_high) mid = hi;
         if (start_point) sta = hi;
         hi++;
         @(negedge clk);
      end
   endtask

   task automatic t_reset;
      chk("R1 scl_high after reset", int'(scl_high), 1);
      chk("R1 scl_low after reset", int'(scl_low), 0);
      chk("R1 no strobes after reset",
          int'(scl_fall | scl_rise | data_point | mid_high | start_point), 0);
   endtask

   task automatic t_basic;
      int lo, hi, dat, mid, sta, r0;
      write_div(2, 1);              // written while idle (R5)
      sda_cfg = 4'd1; start_ext = 1'b0;
      enable = 1'b1;
      @(negedge clk);
      chk("R4 first phase low", int'(scl_low), 1);
      chk("R4 fall strobe at enable", int'(scl_fall), 1);
      meas(lo, hi, dat, mid, sta, r0);
      chk("R2 low length L=2", lo, 24);
      chk("R3 high length H=1", hi, 16);
      chk("R5 idle write used at enable", lo + hi, 40);
      chk("R4 rise strobe only at high start", r0, 1);
      chk("R6 mid offset H=1", mid, 8);
      chk("R7 start offset ext=0", sta, 8);
      chk("R8 data offset cfg=1", dat, 8);
   endtask

   task automatic t_staged;
      int lo, hi, dat, mid, sta, r0;
      // at a fall cycle: write new word while the period runs
      fork
         meas(lo, hi, dat, mid, sta, r0);
         begin
            div_we = 1'b1; div_wdata = {16'd2, 16'd3};
            @(negedge clk);
            div_we = 1'b0;
         end
      join
      chk("R5 running low unchanged", lo, 24);
      chk("R5 running high unchanged", hi, 16);
      meas(lo, hi, dat, mid, sta, r0);
      chk("R5 next low uses new L=3", lo, 32);
      chk("R5 next high uses new H=2", hi, 24);
      chk("R6 mid offset H=2", mid, 12);
   endtask

   task automatic t_ext_and_clamp;
      int lo, hi, dat, mid, sta, r0;
      write_div(5, 0);
      start_ext = 1'b1; sda_cfg = 4'd9;
      meas(lo, hi, dat, mid, sta, r0);   // finishes the L=3/H=2 period
      meas(lo, hi, dat, mid, sta, r0);
      chk("R2 low length L=5", lo, 48);
      chk("R3 high length H=0", hi, 8);
      chk("R6 mid offset H=0", mid, 4);
      chk("R7 start offset ext=1", sta, 6);
      chk("R8 data offset clamped to L", dat, 40);
      sda_cfg = 4'd0;
      #1;
      meas(lo, hi, dat, mid, sta, r0);
      chk("R8 data offset cfg=0", dat, 0);
      start_ext = 1'b0;
   endtask

   task automatic t_disable;
      int lo, hi, dat, mid, sta, r0;
      int seen;
      while (!scl_rise) @(negedge clk);
      enable = 1'b0;
      @(negedge clk);
      chk("R9 released high after disable", int'(scl_high), 1);
      chk("R9 not low after disable", int'(scl_low), 0);
      seen = 0;
      for (int i = 0; i < 20; i++) begin
         if (scl_fall | scl_rise | data_point | mid_high | start_point | scl_low)
            seen++;
         @(negedge clk);
      end
      chk("R1 quiet while disabled", seen, 0);
      write_div(1, 3);
      sda_cfg = 4'd1;
      enable = 1'b1;
      @(negedge clk);
      chk("R9 re-enable starts with fall", int'(scl_fall), 1);
      meas(lo, hi, dat, mid, sta, r0);
      chk("R9 full low after re-enable", lo, 16);
      chk("R3 high length H=3", hi, 32);
      chk("R7 start offset H=3 ext=0", sta, 16);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_vec++;
      n_bad++;
      $display("FAIL watchdog R1 actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      rst_n = 1'b0; enable = 1'b0; div_we = 1'b0; div_wdata = '0;
      start_ext = 1'b0; sda_cfg = 4'd1;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_basic();
      t_staged();
      t_ext_and_clamp();
      t_disable();
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

endmodule